// File: doc/BRIEF.md
# Multi-Speed Bus Cycle Wait-State Generator

This block steps each processor bus cycle through numbered T-states and decides how long the cycle lasts. When a cycle starts, it latches the type of transfer and the class of the target device. It drives the address latch enable in the first T-state. From the second T-state until the cycle ends, it drives one of four command strobes. It raises the processor ready line only in the T-state that ends the cycle.

Targets fall into three speed classes. Devices on the local processor bus finish with no wait states. A fast I/O access that is marked as an NMI trap cycle is stretched to a fixed nine T-states. System-bus devices become medium or slow depending on one sample of the slow-cycle line. That sample is taken at the start of T3 in the lower clock mode and at the start of the first wait state (T4) in the higher clock mode. Medium and slow cycles each have a minimum length that depends on the clock mode. Beyond that minimum, they wait for the external ready line.

Top module: `bus_wait_sequencer`

## Requirements
- R1: While `rst_n` is low, `ale`, all four command strobes and `cpu_rdy` are low. After reset, the block waits idle for `cyc_start`.
- R2: `cyc_start` sampled high while idle begins T1 at that clock edge. `ale` is high for T1 only. From T2 through the final T-state exactly one strobe is high, chosen by `{cyc_io,cyc_wr}` as latched at the start: 00 `mem_rd`, 01 `mem_wr`, 10 `io_rd`, 11 `io_wr`.
- R3: A cycle with `loc_fast` high that is not a trap cycle lasts exactly 4 T-states, and `ext_rdy` has no effect on it.
- R4: A cycle with `loc_fast`, `cyc_io` and `nmi_trap` all high lasts exactly 9 T-states. `nmi_trap` has no effect on memory cycles or on system-bus cycles.
- R5: For system-bus cycles (`loc_fast` low), `slow_req` is sampled only at the clock edge that begins T3 when `hi_speed` is low, and at the edge that begins T4 when `hi_speed` is high. High selects slow, low selects medium. Its value at every other edge is ignored.
- R6: A medium cycle lasts at least 5 T-states when `hi_speed` is low and at least 6 when it is high.
- R7: A slow cycle lasts at least 8 T-states when `hi_speed` is low and at least 10 when it is high.
- R8: Once a medium or slow cycle has reached its minimum, it ends in the first T-state in which `ext_rdy` is high. Until then it adds wait states. A low `ext_rdy` before the minimum does not lengthen the cycle.
- R9: `cpu_rdy` is high only in the final T-state. In the following clock all strobes are low and the block is idle. `cyc_start` and changes to the status inputs during a cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock; one period per T-state |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | Request to begin a bus cycle |
| cyc_io | input | 1 | 1 = I/O space, 0 = memory space |
| cyc_wr | input | 1 | 1 = write, 0 = read |
| loc_fast | input | 1 | Target is on the local processor bus |
| slow_req | input | 1 | Slow-cycle request from the system bus |
| ext_rdy | input | 1 | External ready; low adds wait states |
| nmi_trap | input | 1 | Marks a trapped I/O cycle |
| hi_speed | input | 1 | 1 = higher clock mode |
| ale | output | 1 | Address latch enable |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| cpu_rdy | output | 1 | Ready to the processor |

## Verification
`ale` rises in the clock after the edge that accepts `cyc_start`. The strobe follows one clock later. `cpu_rdy` follows combinationally from `ext_rdy` within the T-state. The bench therefore drives every input on the falling edge, samples one time unit later, and numbers the T-states it walks through, so a measured length equals the index of the T-state that showed `cpu_rdy`.

In every vector, `slow_req` is driven with the opposite value at every edge except the intended sample edge. This makes a wrong sample point produce a wrong length. The clock after `cpu_rdy` is checked for idle outputs.

// File: rtl/twg_pkg.sv
package twg_pkg;

   typedef enum logic [2:0] {
      CLS_IDLE,
      CLS_PEND,
      CLS_MED,
      CLS_SLOW,
      CLS_FAST,
      CLS_TRAP
   } cls_e;

   typedef struct packed {
      logic io;
      logic wr;
      logic hi;
   } attr_t;

endpackage

// File: rtl/twg_tcount.sv
module twg_tcount #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             done,
   output logic             busy,
   output logic [CNT_W-1:0] tcnt
);
   localparam logic [CNT_W-1:0] CMAX = '1;
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         tcnt <= '0;
      end else if (start) begin
         busy <= 1'b1;
         tcnt <= ONE;
      end else if (busy && done) begin
         busy <= 1'b0;
         tcnt <= '0;
      end else if (busy && tcnt != CMAX) begin
         tcnt <= tcnt + ONE;
      end
   end

   // each waiting T-state advances the count by exactly one
   p_tcnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && !start && tcnt != CMAX) |=> (tcnt == $past(tcnt) + ONE));

endmodule

// File: rtl/twg_classify.sv
module twg_classify
   import twg_pkg::*;
#(
   parameter int CNT_W       = 5,
   parameter int LO_SAMPLE_T = 3,
   parameter int HI_SAMPLE_T = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             busy,
   input  logic [CNT_W-1:0] tcnt,
   input  logic             loc_fast,
   input  logic             cyc_io,
   input  logic             cyc_wr,
   input  logic             nmi_trap,
   input  logic             hi_speed,
   input  logic             slow_req,
   output cls_e             cls,
   output attr_t            attr
);
   // the sample edge is the one that leaves T-state (sample point - 1)
   localparam logic [CNT_W-1:0] LO_EDGE = CNT_W'(LO_SAMPLE_T - 1);
   localparam logic [CNT_W-1:0] HI_EDGE = CNT_W'(HI_SAMPLE_T - 1);

   logic [CNT_W-1:0] samp_edge;
   assign samp_edge = attr.hi ? HI_EDGE : LO_EDGE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cls  <= CLS_IDLE;
         attr <= '0;
      end else if (start) begin
         attr <= '{io: cyc_io, wr: cyc_wr, hi: hi_speed};
         if (!loc_fast)
            cls <= CLS_PEND;
         else if (cyc_io && nmi_trap)
            cls <= CLS_TRAP;
         else
            cls <= CLS_FAST;
      end else if (busy && cls == CLS_PEND && tcnt == samp_edge) begin
         cls <= slow_req ? CLS_SLOW : CLS_MED;
      end
   end

   // once decided, the class holds until the cycle ends
   p_class_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start && cls != CLS_PEND) |=> $stable(cls));

endmodule

// File: rtl/twg_strobes.sv
module twg_strobes
   import twg_pkg::*;
#(
   parameter int CNT_W   = 5,
   parameter int N_CMD   = 4,
   parameter int CMD_T   = 2
) (
   input  logic             busy,
   input  logic [CNT_W-1:0] tcnt,
   input  attr_t            attr,
   output logic             ale,
   output logic [N_CMD-1:0] cmd
);
   localparam int SEL_W = $clog2(N_CMD);
   localparam logic [CNT_W-1:0] T1   = CNT_W'(1);
   localparam logic [CNT_W-1:0] TCMD = CNT_W'(CMD_T);

   logic [SEL_W-1:0] sel;
   logic             cmd_phase;

   assign sel       = SEL_W'({attr.io, attr.wr});
   assign cmd_phase = busy && (tcnt >= TCMD);
   assign ale       = busy && (tcnt == T1);

   for (genvar gi = 0; gi < N_CMD; gi++) begin : g_cmd
      assign cmd[gi] = cmd_phase && (sel == SEL_W'(gi));
   end

endmodule

// File: rtl/bus_wait_sequencer.sv
module bus_wait_sequencer
   import twg_pkg::*;
#(
   parameter int CNT_W       = 5,
   parameter int FAST_LEN    = 4,
   parameter int TRAP_LEN    = 9,
   parameter int LO_SAMPLE_T = 3,
   parameter int HI_SAMPLE_T = 4,
   parameter int LO_MED_MIN  = 5,
   parameter int HI_MED_MIN  = 6,
   parameter int LO_SLOW_MIN = 8,
   parameter int HI_SLOW_MIN = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_start,
   input  logic cyc_io,
   input  logic cyc_wr,
   input  logic loc_fast,
   input  logic slow_req,
   input  logic ext_rdy,
   input  logic nmi_trap,
   input  logic hi_speed,
   output logic ale,
   output logic mem_rd,
   output logic mem_wr,
   output logic io_rd,
   output logic io_wr,
   output logic cpu_rdy
);
   localparam int N_CMD   = 4;
   localparam int LONGEST = (HI_SLOW_MIN > TRAP_LEN) ? HI_SLOW_MIN : TRAP_LEN;
   localparam logic [CNT_W-1:0] C_FAST  = CNT_W'(FAST_LEN);
   localparam logic [CNT_W-1:0] C_TRAP  = CNT_W'(TRAP_LEN);
   localparam logic [CNT_W-1:0] C_LMED  = CNT_W'(LO_MED_MIN);
   localparam logic [CNT_W-1:0] C_HMED  = CNT_W'(HI_MED_MIN);
   localparam logic [CNT_W-1:0] C_LSLOW = CNT_W'(LO_SLOW_MIN);
   localparam logic [CNT_W-1:0] C_HSLOW = CNT_W'(HI_SLOW_MIN);

   if (LO_SAMPLE_T < 3 || HI_SAMPLE_T < LO_SAMPLE_T) begin : g_bad_sample
      $error("sample points must lie at or after T3");
   end
   if (LO_MED_MIN <= LO_SAMPLE_T || HI_MED_MIN <= HI_SAMPLE_T) begin : g_bad_med
      $error("medium minimum must follow the sample point");
   end
   if (LO_SLOW_MIN < LO_MED_MIN || HI_SLOW_MIN < HI_MED_MIN) begin : g_bad_slow
      $error("slow minimum shorter than medium minimum");
   end
   if (FAST_LEN < 2 || (2 ** CNT_W) - 1 <= LONGEST) begin : g_bad_cnt
      $error("counter too narrow or fast cycle too short");
   end

   logic             busy, start, done;
   logic [CNT_W-1:0] tcnt;
   logic [CNT_W-1:0] med_min, slow_min;
   cls_e             cls;
   attr_t            attr;
   logic [N_CMD-1:0] cmd;

   assign start = !busy && cyc_start;

   twg_tcount #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .start(start), .done(done),
      .busy(busy), .tcnt(tcnt)
   );

   twg_classify #(
      .CNT_W(CNT_W), .LO_SAMPLE_T(LO_SAMPLE_T), .HI_SAMPLE_T(HI_SAMPLE_T)
   ) u_cls (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .tcnt(tcnt),
      .loc_fast(loc_fast), .cyc_io(cyc_io), .cyc_wr(cyc_wr),
      .nmi_trap(nmi_trap), .hi_speed(hi_speed), .slow_req(slow_req),
      .cls(cls), .attr(attr)
   );

   twg_strobes #(.CNT_W(CNT_W), .N_CMD(N_CMD), .CMD_T(2)) u_stb (
      .busy(busy), .tcnt(tcnt), .attr(attr), .ale(ale), .cmd(cmd)
   );

   assign med_min  = attr.hi ? C_HMED  : C_LMED;
   assign slow_min = attr.hi ? C_HSLOW : C_LSLOW;

   always_comb begin
      unique case (cls)
         CLS_FAST: done = busy && (tcnt == C_FAST);
         CLS_TRAP: done = busy && (tcnt == C_TRAP);
         CLS_MED:  done = busy && (tcnt >= med_min)  && ext_rdy;
         CLS_SLOW: done = busy && (tcnt >= slow_min) && ext_rdy;
         default:  done = 1'b0;
      endcase
   end

   assign cpu_rdy = done;
   assign mem_rd  = cmd[0];
   assign mem_wr  = cmd[1];
   assign io_rd   = cmd[2];
   assign io_wr   = cmd[3];

   p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> (!ale && !cpu_rdy));

   p_cmd_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd, mem_wr, io_rd, io_wr}));

   p_cmd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd || mem_wr || io_rd || io_wr) && !cpu_rdy)
      |=> $stable({mem_rd, mem_wr, io_rd, io_wr}));

   p_rdy_final_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rdy |=> (!cpu_rdy && !mem_rd && !mem_wr && !io_rd && !io_wr));

   p_rdy_needs_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rdy |-> (cls != CLS_PEND && cls != CLS_IDLE));

   p_rdy_after_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rdy |-> (mem_rd || mem_wr || io_rd || io_wr));

endmodule

// File: tb/tb_bus_wait_sequencer.sv
module tb_bus_wait_sequencer;
   localparam int CLK_P = 10;

   typedef struct packed {
      logic io; logic wr; logic fast; logic slow; logic trap; logic hi;
      logic [7:0] hold; logic [7:0] len;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'd0,  8'd4 },  // R3 fast mem rd lo
      '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b1, 8'd0,  8'd4 },  // R3 fast io wr hi
      '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0, 8'd0,  8'd9 },  // R4 trap lo
      '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1, 8'd20, 8'd9 },  // R4 trap hi, ext ignored
      '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 8'd0,  8'd4 },  // R4 trap ignored on memory
      '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd0,  8'd5 },  // R6 medium lo
      '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 8'd0,  8'd6 },  // R6 medium hi
      '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 8'd0,  8'd8 },  // R7 slow lo
      '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1, 8'd0,  8'd10},  // R7 slow hi
      '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd7,  8'd8 },  // R8 medium lo extended
      '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1, 8'd12, 8'd13},  // R8 slow hi extended
      '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 8'd6,  8'd4 },  // R3 ext ignored on fast
      '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 8'd0,  8'd5 },  // R4 trap ignored on system bus
      '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 8'd3,  8'd6 },  // R8 early low ext no effect
      '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'd4,  8'd8 }   // R8 slow lo, low before min
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic cyc_start = 0, cyc_io = 0, cyc_wr = 0, loc_fast = 0, slow_req = 0;
   logic ext_rdy = 1, nmi_trap = 0, hi_speed = 0;
   logic ale, mem_rd, mem_wr, io_rd, io_wr, cpu_rdy;
   int n_chk = 0, n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   bus_wait_sequencer dut (
      .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_io(cyc_io),
      .cyc_wr(cyc_wr), .loc_fast(loc_fast), .slow_req(slow_req),
      .ext_rdy(ext_rdy), .nmi_trap(nmi_trap), .hi_speed(hi_speed),
      .ale(ale), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd),
      .io_wr(io_wr), .cpu_rdy(cpu_rdy)
   );

   function automatic logic [5:0] outs();
      return {ale, io_wr, io_rd, mem_wr, mem_rd, cpu_rdy};
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // runs one cycle; returns the index of the T-state showing ready
   task automatic run_vec(input vec_t v, input string tag);
      int samp = v.hi ? 4 : 3;
      int len = 0;
      int ale_bad = 0, cmd_bad = 0;
      logic [3:0] exp_cmd = 4'b0001 << {v.io, v.wr};
      @(negedge clk);
      cyc_start = 1; cyc_io = v.io; cyc_wr = v.wr; loc_fast = v.fast;
      nmi_trap = v.trap; hi_speed = v.hi; slow_req = !v.slow;
      ext_rdy = (0 > v.hold);
      for (int k = 1; k <= 40; k++) begin
         @(negedge clk);
         cyc_start = 0;
         cyc_io = !v.io; cyc_wr = !v.wr; hi_speed = !v.hi;
         slow_req = (k == samp - 1) ? v.slow : !v.slow;
         ext_rdy = (k > int'(v.hold));
         #1;
         if (ale != (k == 1)) ale_bad++;
         if ({io_wr, io_rd, mem_wr, mem_rd} != ((k >= 2) ? exp_cmd : 4'b0)) cmd_bad++;
         if (cpu_rdy) begin
            len = k;
            break;
         end
      end
      check({tag, " length"}, len, int'(v.len));
      check("R2 ale only in T1", ale_bad, 0);
      check("R2 strobe select", cmd_bad, 0);
      @(negedge clk);
      ext_rdy = 1; #1;
      check("R9 idle after ready", int'(outs()), 0);
   endtask

   initial begin
      #(CLK_P * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_P * 3 + 2);
      check("R1 reset outputs", int'(outs()), 0);
      rst_n = 1;
      @(negedge clk); #1;
      check("R1 idle after reset", int'(outs()), 0);

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = VECS[i].fast ? (VECS[i].trap && VECS[i].io ? "R4" : "R3")
                            : (VECS[i].hold != 0 ? "R8"
                            : (VECS[i].slow ? "R7 R5" : "R6 R5"));
         run_vec(VECS[i], tag);
      end

      // R9: start request during a cycle is ignored
      begin
         int len = 0, bad = 0;
         @(negedge clk);
         cyc_start = 1; cyc_io = 0; cyc_wr = 0; loc_fast = 0; hi_speed = 0;
         slow_req = 0; ext_rdy = 1; nmi_trap = 0;
         for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            cyc_start = (k >= 2 && k <= 4); cyc_io = 1; loc_fast = 1; #1;
            if (k >= 2 && !mem_rd) bad++;
            if (cpu_rdy) begin len = k; break; end
         end
         check("R9 busy start ignored length", len, 5);
         check("R9 busy strobe kept", bad, 0);
         @(negedge clk); cyc_start = 0; #1;
         check("R9 no restart after end", int'(outs()), 0);
         @(negedge clk); #1;
         check("R9 still idle", int'(outs()), 0);
      end

      // R1: reset in the middle of a cycle
      @(negedge clk);
      cyc_start = 1; cyc_io = 1; cyc_wr = 1; loc_fast = 0; hi_speed = 1;
      @(negedge clk); cyc_start = 0;
      @(negedge clk); #1;
      check("R2 io_wr active before reset", int'(io_wr), 1);
      rst_n = 0; #1;
      check("R1 mid-cycle reset", int'(outs()), 0);
      @(negedge clk); rst_n = 1;
      @(negedge clk); #1;
      check("R1 idle after mid reset", int'(outs()), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule